// File: doc/BRIEF.md
# Auto-DMA Audio Input Ring Writer

This block takes a stream of 16-bit samples arriving over DMA and lays them into a small stereo input ring that lives in sound RAM. A transfer starts with a request carrying a byte count. When the requesting core is in auto mode, the block moves whole blocks of 512 halfwords. The first 256 halfwords of each block go to that core's left region and the following 256 go to its right region. The write position inside each region toggles between 0 and 256 after every block.

A free-space counter, held in halfwords, limits how far the writer can run ahead of the mixer. Each block lowers it by 512. A consumer pulse raises it by 512, and it never goes above the ring size of 1024.

Each core has a watch address and a watch enable. After every block, every enabled watch that lies inside either half-span just written produces an interrupt pulse for its core.

A request that cannot move even one block ends at once with zero bytes and a retry flag. A request from a core that is not in auto mode ends with zero bytes and no retry.

Top module: `adma_ring_writer`

## Requirements
- R1: Auto mode is on for the requesting core only when every bit of (core_id + 1) is set in `auto_ctrl`. For core 0 that is bit 0, and for core 1 it is bit 1. A request in any other case completes without writing, with `done_bytes` = 0 and `done_retry` = 0.
- R2: On any request made in auto mode, `tsa_masked` takes `start_addr` with everything above bit 12 cleared. The new value is visible one cycle after the request is accepted.
- R3: A block is started only when free space is non-zero and at least 1024 bytes of the request remain. A block is never cut short. Once the last block ends, no further RAM write occurs.
- R4: Within a block, word k (0..511) is written to `0x2000 + 0x200*(k/256) + 0x400*core + pos + (k mod 256)`, with `ram_wdata` equal to the accepted `in_data`. One word is written per cycle in which `in_valid` and `in_ready` are both high.
- R5: After each block, `pos` steps by 256 modulo 512, starting from 0 at reset, and free space drops by 512. Back-to-back blocks continue without a gap.
- R6: For each half-span of a block (start S, 256 words) and for each core c, a hit is recorded when `watch_en[c]` is set and `S <= watch_addr[c] < S+256`. Core c's watch occupies bits `[20*c +: 20]`. Both cores are checked against every span, whichever core is transferring.
- R7: `done_o` pulses for one cycle when a request ends. `done_bytes` then equals 1024 times the number of blocks moved. `done_retry` is 1 exactly when auto mode was on and no block moved.
- R8: A `cons_take` pulse raises `free_words` by 512, saturating at 1024. Reset sets `free_words` to 1024.
- R9: The hits of a block appear on `irq` (bit c for core c) as a single-cycle pulse in the cycle after the block's last word is written. Both halves' hits for a core merge into that one pulse.
- R10: After reset, `req_ready`=1, `in_ready`=0, `ram_we`=0, `done_o`=0, `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_id | input | 1 | Core that owns the request |
| auto_ctrl | input | 2 | Auto-mode control bits, one per core |
| start_addr | input | 20 | Transfer start address from the requester |
| req_valid | input | 1 | Request strobe, taken while `req_ready` |
| req_bytes | input | 16 | Byte count of the request |
| req_ready | output | 1 | Idle and able to take a request |
| done_o | output | 1 | One-cycle end-of-request pulse |
| done_bytes | output | 16 | Bytes consumed by the finished request |
| done_retry | output | 1 | Finished request asks to be retried later |
| tsa_masked | output | 20 | Start address masked to 13 bits |
| in_valid | input | 1 | Sample available |
| in_ready | output | 1 | Sample accepted this cycle if valid |
| in_data | input | 16 | Sample halfword |
| ram_we | output | 1 | Sound-RAM write strobe |
| ram_addr | output | 20 | Sound-RAM halfword address |
| ram_wdata | output | 16 | Sound-RAM write data |
| cons_take | input | 1 | Mixer has drained 512 halfwords |
| free_words | output | 11 | Free ring space in halfwords |
| watch_addr | input | 40 | Watch address per core, 20 bits each |
| watch_en | input | 2 | Watch enable per core |
| irq | output | 2 | Watch interrupt pulse per core |

## Verification
A wrong position register moves every address in the next block by 256 words. The very first write of that block shows it on `ram_addr`. A drifting free-space count shows up on `free_words` right away, and changes the block count that `done_bytes` reports when the request ends. A wrong core latch or stale watch compare appears as a missing or extra `irq` bit in the single cycle after the block's last word. The bench therefore checks every write of every block and every block-end cycle, over a sweep of watch addresses placed on both bounds of both half-spans.

// File: rtl/adma_ring_pkg.sv
// Package: shared types for the auto-DMA input ring writer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package adma_ring_pkg;

    // Sequencer state: idle waiting for a request, or moving block words.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_MOVE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/adma_space_track.sv
// Module: adma_space_track
// Keeps the ring write position and the free-space count.
// Assumes blk_done is only raised when free_q >= BLOCK_WORDS, and that
// HALF_WORDS < BLOCK_WORDS <= RING_WORDS.
module adma_space_track #(
    parameter int RING_WORDS  = 1024,
    parameter int BLOCK_WORDS = 512,
    parameter int HALF_WORDS  = 256,
    parameter int FREE_W      = $clog2(RING_WORDS + 1),
    parameter int POS_W       = $clog2(BLOCK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_done,
    input  logic              cons_take,
    output logic [FREE_W-1:0] free_q,
    output logic [FREE_W-1:0] free_after,
    output logic [POS_W-1:0]  pos_q
);

    localparam int POS_WRAP = BLOCK_WORDS - HALF_WORDS;

    logic [FREE_W-1:0] free_less;
    logic [FREE_W:0]   free_plus;
    logic [POS_W-1:0]  pos_d;

    // Next free count: subtract a finished block, then add a drained chunk with saturation.
    always_comb begin
        free_less = free_q - (blk_done ? FREE_W'(BLOCK_WORDS) : FREE_W'(0));
        free_plus = {1'b0, free_less} + (FREE_W + 1)'(BLOCK_WORDS);
        if (cons_take) begin
            free_after = (free_plus > (FREE_W + 1)'(RING_WORDS)) ?
                         FREE_W'(RING_WORDS) : free_plus[FREE_W-1:0];
        end else begin
            free_after = free_less;
        end
    end

    // Next position: advance by a half-block, wrapping inside one side's region.
    always_comb begin
        if (pos_q >= POS_W'(POS_WRAP)) begin
            pos_d = pos_q - POS_W'(POS_WRAP);
        end else begin
            pos_d = pos_q + POS_W'(HALF_WORDS);
        end
    end

    // Register free count and position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= FREE_W'(RING_WORDS);
            pos_q  <= '0;
        end else begin
            free_q <= free_after;
            if (blk_done) begin
                pos_q <= pos_d;
            end
        end
    end

endmodule

// File: rtl/adma_watch_cmp.sv
// Module: adma_watch_cmp
// Compares every core's watch address against the two half-spans of the
// block being written. Purely combinational.
// Assumes spans do not wrap past the top of the address space.
module adma_watch_cmp #(
    parameter int NCORES      = 2,
    parameter int CORE_W      = 1,
    parameter int ADDR_W      = 20,
    parameter int POS_W       = 9,
    parameter int HALF_WORDS  = 256,
    parameter int BASE_L      = 'h2000,
    parameter int BASE_R      = 'h2200,
    parameter int CORE_STRIDE = 'h400
) (
    input  logic [CORE_W-1:0]        core_q,
    input  logic [POS_W-1:0]         pos_q,
    input  logic [NCORES*ADDR_W-1:0] watch_addr,
    input  logic [NCORES-1:0]        watch_en,
    output logic [NCORES-1:0]        hits
);

    localparam int NHALF = 2;

    logic [ADDR_W-1:0] span_lo [NHALF];
    logic [ADDR_W-1:0] span_hi [NHALF];

    // Span bounds for the left and right halves.
    for (genvar h = 0; h < NHALF; h++) begin : g_span
        localparam int HBASE = (h == 0) ? BASE_L : BASE_R;
        assign span_lo[h] = ADDR_W'(HBASE) + ADDR_W'(core_q) * ADDR_W'(CORE_STRIDE)
                          + ADDR_W'(pos_q);
        assign span_hi[h] = span_lo[h] + ADDR_W'(HALF_WORDS);
    end

    // Per-core hit: any half-span contains the enabled watch address.
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        logic [ADDR_W-1:0] wa;
        logic [NHALF-1:0]  half_hit;
        assign wa = watch_addr[c*ADDR_W +: ADDR_W];
        for (genvar h = 0; h < NHALF; h++) begin : g_half
            assign half_hit[h] = watch_en[c] && (wa >= span_lo[h]) && (wa < span_hi[h]);
        end
        assign hits[c] = |half_hit;
    end

endmodule

// File: rtl/adma_seq_ctl.sv
// Module: adma_seq_ctl
// Request sequencer: decodes auto mode, decides whether a block can start,
// counts block words, and reports completion and watch interrupts.
// Assumes core_id, auto_ctrl, start_addr and req_bytes are valid with req_valid.
module adma_seq_ctl
    import adma_ring_pkg::*;
#(
    parameter int NCORES      = 2,
    parameter int CORE_W      = 1,
    parameter int ADDR_W      = 20,
    parameter int BYTES_W     = 16,
    parameter int FREE_W      = 11,
    parameter int BLOCK_WORDS = 512,
    parameter int TSA_BITS    = 13,
    parameter int WC_W        = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic [CORE_W-1:0]  core_id,
    input  logic [NCORES-1:0]  auto_ctrl,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [FREE_W-1:0]  free_q,
    input  logic [FREE_W-1:0]  free_after,
    input  logic               in_valid,
    input  logic [NCORES-1:0]  hits,
    output logic               req_ready,
    output logic               in_ready,
    output logic [WC_W-1:0]    word_cnt,
    output logic [CORE_W-1:0]  core_q,
    output logic               blk_done,
    output logic               done_o,
    output logic [BYTES_W-1:0] done_bytes,
    output logic               done_retry,
    output logic [ADDR_W-1:0]  tsa_masked,
    output logic [NCORES-1:0]  irq
);

    localparam int BLOCK_BYTES = 2 * BLOCK_WORDS;
    localparam int TSA_KEEP    = (1 << TSA_BITS) - 1;

    seq_state_e         state_q;
    logic [BYTES_W-1:0] rem_q;
    logic [BYTES_W-1:0] proc_q;
    logic [BYTES_W-1:0] rem_after;
    logic [NCORES-1:0]  core_mask;
    logic               auto_on;
    logic               can_start;
    logic               fire;
    logic               go_on;

    // Auto-mode decode and start condition for a fresh request.
    always_comb begin
        core_mask = NCORES'(core_id) + NCORES'(1);
        auto_on   = (auto_ctrl & core_mask) == core_mask;
        can_start = auto_on && (free_q != '0) && (req_bytes >= BYTES_W'(BLOCK_BYTES));
    end

    // Word handshake and end-of-block continuation decision.
    always_comb begin
        req_ready = (state_q == SEQ_IDLE);
        in_ready  = (state_q == SEQ_MOVE);
        fire      = in_ready && in_valid;
        blk_done  = fire && (word_cnt == WC_W'(BLOCK_WORDS - 1));
        rem_after = rem_q - BYTES_W'(BLOCK_BYTES);
        go_on     = (free_after != '0) && (rem_after >= BYTES_W'(BLOCK_BYTES));
    end

    // Sequencer state, counters and one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            rem_q      <= '0;
            proc_q     <= '0;
            word_cnt   <= '0;
            core_q     <= '0;
            done_o     <= 1'b0;
            done_bytes <= '0;
            done_retry <= 1'b0;
            tsa_masked <= '0;
            irq        <= '0;
        end else begin
            done_o <= 1'b0;
            irq    <= '0;
            case (state_q)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        core_q <= core_id;
                        if (auto_on) begin
                            tsa_masked <= start_addr & ADDR_W'(TSA_KEEP);
                        end
                        if (can_start) begin
                            state_q  <= SEQ_MOVE;
                            rem_q    <= req_bytes;
                            proc_q   <= '0;
                            word_cnt <= '0;
                        end else begin
                            done_o     <= 1'b1;
                            done_bytes <= '0;
                            done_retry <= auto_on;
                        end
                    end
                end
                SEQ_MOVE: begin
                    if (fire) begin
                        word_cnt <= blk_done ? WC_W'(0) : word_cnt + WC_W'(1);
                    end
                    if (blk_done) begin
                        irq    <= hits;
                        rem_q  <= rem_after;
                        proc_q <= proc_q + BYTES_W'(BLOCK_BYTES);
                        if (!go_on) begin
                            state_q    <= SEQ_IDLE;
                            done_o     <= 1'b1;
                            done_bytes <= proc_q + BYTES_W'(BLOCK_BYTES);
                            done_retry <= 1'b0;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adma_ring_writer.sv
// Module: adma_ring_writer (top)
// Streams DMA halfwords into a stereo input ring in sound RAM: each block
// goes half to the core's left region, half to its right region.
// Tracks position and free space, and pulses per-core watch interrupts.
// Assumes in_data is valid with in_valid, and that watch inputs stay
// stable during a block.
module adma_ring_writer #(
    parameter int NCORES      = 2,
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int BYTES_W     = 16,
    parameter int HALF_WORDS  = 256,
    parameter int RING_WORDS  = 1024,
    parameter int BASE_L      = 'h2000,
    parameter int BASE_R      = 'h2200,
    parameter int CORE_STRIDE = 'h400,
    parameter int TSA_BITS    = 13,
    localparam int CORE_W     = $clog2(NCORES),
    localparam int FREE_W     = $clog2(RING_WORDS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CORE_W-1:0]        core_id,
    input  logic [NCORES-1:0]        auto_ctrl,
    input  logic [ADDR_W-1:0]        start_addr,
    input  logic                     req_valid,
    input  logic [BYTES_W-1:0]       req_bytes,
    output logic                     req_ready,
    output logic                     done_o,
    output logic [BYTES_W-1:0]       done_bytes,
    output logic                     done_retry,
    output logic [ADDR_W-1:0]        tsa_masked,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [DATA_W-1:0]        in_data,
    output logic                     ram_we,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic                     cons_take,
    output logic [FREE_W-1:0]        free_words,
    input  logic [NCORES*ADDR_W-1:0] watch_addr,
    input  logic [NCORES-1:0]        watch_en,
    output logic [NCORES-1:0]        irq
);

    localparam int BLOCK_WORDS = 2 * HALF_WORDS;
    localparam int POS_W       = $clog2(BLOCK_WORDS);
    localparam int WC_W        = POS_W;

    logic [FREE_W-1:0] free_after;
    logic [POS_W-1:0]  pos_q;
    logic [WC_W-1:0]   word_cnt;
    logic [CORE_W-1:0] core_q;
    logic              blk_done;
    logic [NCORES-1:0] hits;
    logic [ADDR_W-1:0] seg_base;

    adma_space_track #(
        .RING_WORDS (RING_WORDS),
        .BLOCK_WORDS(BLOCK_WORDS),
        .HALF_WORDS (HALF_WORDS),
        .FREE_W     (FREE_W),
        .POS_W      (POS_W)
    ) u_space (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_done  (blk_done),
        .cons_take (cons_take),
        .free_q    (free_words),
        .free_after(free_after),
        .pos_q     (pos_q)
    );

    adma_watch_cmp #(
        .NCORES     (NCORES),
        .CORE_W     (CORE_W),
        .ADDR_W     (ADDR_W),
        .POS_W      (POS_W),
        .HALF_WORDS (HALF_WORDS),
        .BASE_L     (BASE_L),
        .BASE_R     (BASE_R),
        .CORE_STRIDE(CORE_STRIDE)
    ) u_watch (
        .core_q    (core_q),
        .pos_q     (pos_q),
        .watch_addr(watch_addr),
        .watch_en  (watch_en),
        .hits      (hits)
    );

    adma_seq_ctl #(
        .NCORES     (NCORES),
        .CORE_W     (CORE_W),
        .ADDR_W     (ADDR_W),
        .BYTES_W    (BYTES_W),
        .FREE_W     (FREE_W),
        .BLOCK_WORDS(BLOCK_WORDS),
        .TSA_BITS   (TSA_BITS),
        .WC_W       (WC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bytes (req_bytes),
        .core_id   (core_id),
        .auto_ctrl (auto_ctrl),
        .start_addr(start_addr),
        .free_q    (free_words),
        .free_after(free_after),
        .in_valid  (in_valid),
        .hits      (hits),
        .req_ready (req_ready),
        .in_ready  (in_ready),
        .word_cnt  (word_cnt),
        .core_q    (core_q),
        .blk_done  (blk_done),
        .done_o    (done_o),
        .done_bytes(done_bytes),
        .done_retry(done_retry),
        .tsa_masked(tsa_masked),
        .irq       (irq)
    );

    // Sound-RAM write port: upper word-count bit picks the right half.
    always_comb begin
        seg_base  = word_cnt[WC_W-1] ? ADDR_W'(BASE_R) : ADDR_W'(BASE_L);
        ram_we    = in_ready && in_valid;
        ram_addr  = seg_base + ADDR_W'(core_q) * ADDR_W'(CORE_STRIDE)
                  + ADDR_W'(pos_q) + ADDR_W'(word_cnt[WC_W-2:0]);
        ram_wdata = in_data;
    end

endmodule

// File: rtl/adma_ring_writer_chk.sv
// Module: adma_ring_writer_chk
// Checker bound to the ring writer top: port-level temporal properties.
// Assumes the default core count and region layout passed in by the bind.
module adma_ring_writer_chk #(
    parameter int NCORES     = 2,
    parameter int ADDR_W     = 20,
    parameter int FREE_W     = 11,
    parameter int RING_WORDS = 1024,
    parameter int REGION_LO  = 'h2000,
    parameter int REGION_HI  = 'h2800
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FREE_W-1:0] free_words,
    input logic [NCORES-1:0] irq,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              in_ready,
    input logic              req_ready,
    input logic              done_o
);

    // R8: free space never exceeds the ring size.
    a_r8_free_cap: assert property (@(posedge clk) disable iff (!rst_n)
        free_words <= FREE_W'(RING_WORDS));

    // R9: an interrupt pulse lasts exactly one cycle.
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |=> (irq == '0));

    // R6: an interrupt only follows a cycle that wrote sound RAM.
    a_r6_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> $past(ram_we));

    // R4: every write lands inside the ring regions.
    a_r4_region: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ((ram_addr >= ADDR_W'(REGION_LO)) && (ram_addr < ADDR_W'(REGION_HI))));

    // R3: the block never takes a request while moving data.
    a_r3_mode_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && req_ready));

    // R7: completion is reported only when idle.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_ready);

endmodule

bind adma_ring_writer adma_ring_writer_chk #(
    .NCORES    (NCORES),
    .ADDR_W    (ADDR_W),
    .FREE_W    (FREE_W),
    .RING_WORDS(RING_WORDS),
    .REGION_LO (BASE_L),
    .REGION_HI (BASE_R + (NCORES - 1) * CORE_STRIDE + 2 * HALF_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .free_words(free_words),
    .irq       (irq),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .in_ready  (in_ready),
    .req_ready (req_ready),
    .done_o    (done_o)
);

// File: tb/adma_ring_writer_tb.sv
// Bench for adma_ring_writer: sweeps cores, modes, byte counts, free-space
// states and watch positions; expected values computed arithmetically.
module adma_ring_writer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BLK_WORDS  = 512;
    localparam int BLK_BYTES  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  core_id = '0;
    logic [1:0]  auto_ctrl = '0;
    logic [19:0] start_addr = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_bytes = '0;
    logic        req_ready;
    logic        done_o;
    logic [15:0] done_bytes;
    logic        done_retry;
    logic [19:0] tsa_masked;
    logic        in_valid = 1'b1;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        ram_we;
    logic [19:0] ram_addr;
    logic [15:0] ram_wdata;
    logic        cons_take = 1'b0;
    logic [10:0] free_words;
    logic [39:0] watch_addr = '0;
    logic [1:0]  watch_en = '0;
    logic [1:0]  irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit ended    = 0;
    int m_free   = 1024;
    int m_pos    = 0;

    adma_ring_writer u_dut (
        .clk(clk), .rst_n(rst_n), .core_id(core_id), .auto_ctrl(auto_ctrl),
        .start_addr(start_addr), .req_valid(req_valid), .req_bytes(req_bytes),
        .req_ready(req_ready), .done_o(done_o), .done_bytes(done_bytes),
        .done_retry(done_retry), .tsa_masked(tsa_masked), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .cons_take(cons_take), .free_words(free_words),
        .watch_addr(watch_addr), .watch_en(watch_en), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got cycle %0d exp below 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h exp %0h", tag, act, exp);
        end
    endtask

    function automatic int offv(input int k);
        case (k)
            0: return -1;
            1: return 0;
            2: return 255;
            default: return 256;
        endcase
    endfunction

    // Expected watch hits for one block of core 'core' at position 'pos'.
    function automatic logic [1:0] exp_hits(input int core, input int pos,
                                            input int w0, input int w1, input int wen);
        logic [1:0] r = '0;
        for (int c = 0; c < 2; c++) begin
            int wa = (c == 0) ? w0 : w1;
            for (int h = 0; h < 2; h++) begin
                int s = 'h2000 + h * 'h200 + core * 'h400 + pos;
                if (((wen >> c) & 1) == 1 && wa >= s && wa < s + 256) r[c] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic consume(input string tag);
        @(negedge clk);
        cons_take = 1'b1;
        @(negedge clk);
        cons_take = 1'b0;
        m_free = (m_free + 512 > 1024) ? 1024 : m_free + 512;
        #1 chk({tag, " R8 free after consume"}, 32'(free_words), 32'(m_free));
    endtask

    task automatic do_req(input int core, input int actl, input int bytes, input int sa,
                          input int w0, input int w1, input int wen, input string tag);
        bit         auto_m;
        int         nblk = 0;
        int         f = m_free;
        int         rem = bytes;
        logic [1:0] prev = '0;
        auto_m = ((actl & (core + 1)) == (core + 1));
        if (auto_m) begin
            while (f > 0 && rem >= BLK_BYTES) begin
                nblk++;
                f -= 512;
                rem -= BLK_BYTES;
            end
        end
        @(negedge clk);
        core_id    = core[0:0];
        auto_ctrl  = actl[1:0];
        start_addr = sa[19:0];
        req_bytes  = bytes[15:0];
        watch_addr = {w1[19:0], w0[19:0]};
        watch_en   = wen[1:0];
        req_valid  = 1'b1;
        if (nblk == 0) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk({tag, " R7 done pulse"}, 32'(done_o), 1);
            chk({tag, " R7 zero bytes"}, 32'(done_bytes), 0);
            chk({tag, " R7 retry flag"}, 32'(done_retry), 32'(auto_m));
            chk({tag, " R3 no write"}, 32'(ram_we), 0);
            chk({tag, " R1 idle"}, 32'(req_ready), 1);
            chk({tag, " R5 free kept"}, 32'(free_words), 32'(m_free));
            if (auto_m) chk({tag, " R2 masked start"}, 32'(tsa_masked), 32'(sa & 'h1FFF));
        end else begin
            for (int b = 0; b < nblk; b++) begin
                logic [1:0] hb = exp_hits(core, m_pos, w0, w1, wen);
                for (int w = 0; w < BLK_WORDS; w++) begin
                    int ea = 'h2000 + (w / 256) * 'h200 + core * 'h400 + m_pos + (w % 256);
                    @(negedge clk);
                    req_valid = 1'b0;
                    in_data = 16'(b * 'h1000 + w * 7 + core);
                    #1;
                    if (w == 0) begin
                        chk({tag, " R9 irq at block start"}, 32'(irq), 32'(prev));
                        if (b == 0) chk({tag, " R2 masked start"}, 32'(tsa_masked), 32'(sa & 'h1FFF));
                    end
                    chk({tag, " R4 write strobe"}, 32'(ram_we), 1);
                    chk({tag, " R4 write address"}, 32'(ram_addr), 32'(ea));
                    chk({tag, " R4 write data"}, 32'(ram_wdata), 32'(in_data));
                end
                prev   = hb;
                m_pos  = (m_pos + 256) % 512;
                m_free -= 512;
            end
            @(negedge clk);
            #1;
            chk({tag, " R6 R9 irq after last word"}, 32'(irq), 32'(prev));
            chk({tag, " R7 done pulse"}, 32'(done_o), 1);
            chk({tag, " R7 byte count"}, 32'(done_bytes), 32'(nblk * BLK_BYTES));
            chk({tag, " R7 no retry"}, 32'(done_retry), 0);
            chk({tag, " R3 stop after last block"}, 32'(ram_we), 0);
            chk({tag, " R5 free after blocks"}, 32'(free_words), 32'(m_free));
            @(negedge clk);
            #1;
            chk({tag, " R9 irq single cycle"}, 32'(irq), 0);
            chk({tag, " R7 done single cycle"}, 32'(done_o), 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 req_ready", 32'(req_ready), 1);
        chk("R10 in_ready", 32'(in_ready), 0);
        chk("R10 ram_we", 32'(ram_we), 0);
        chk("R10 done", 32'(done_o), 0);
        chk("R10 irq", 32'(irq), 0);
        chk("R8 R10 free at reset", 32'(free_words), 1024);

        // R1: mode decode, every core/control combination that is off.
        do_req(0, 0, 'h800, 'h01234, 0, 0, 0, "R1 core0 ctrl0");
        do_req(0, 2, 'h800, 'h01234, 0, 0, 0, "R1 core0 ctrl2");
        do_req(1, 1, 'h800, 'h01234, 0, 0, 0, "R1 core1 ctrl1");
        do_req(1, 0, 'h800, 'h01234, 0, 0, 0, "R1 core1 ctrl0");
        // R3: one byte short of a block, with address masking.
        do_req(0, 1, 'h3FF, 'hFE5A7, 0, 0, 0, "R3 short request");
        // R3 R5: 2.5 blocks with room for two; right-half hit on second block.
        do_req(0, 1, 'hA00, 'h12345, 'h20FF, 'h2300, 3, "R3 two of three");
        // R3: ring full stalls even in auto mode.
        do_req(1, 3, 'h400, 'h1FFFF, 0, 0, 0, "R3 ring full");
        // R8: refill and saturation.
        consume("R8 a");
        consume("R8 b");
        consume("R8 c");
        // R4 R6: core 1 region, core 0 watch on its first word.
        do_req(1, 2, 'h1000, 'h0ABCD, 'h2600, 'h25FF, 3, "R4 core1 run");
        // R6 sweep: both bounds of both halves, both cores, both positions.
        for (int t = 0; t < 16; t++) begin
            int core = t & 1;
            int w0 = 'h2000 + ((t >> 2) & 1) * 'h200 + core * 'h400 + m_pos + offv(t % 4);
            int w1 = 'h2000 + ((t >> 1) & 1) * 'h200 + core * 'h400 + m_pos + offv((t + 2) % 4);
            int wen = (t % 5 == 3) ? 1 : ((t % 7 == 4) ? 2 : 3);
            consume("R8 refill");
            consume("R8 refill");
            do_req(core, core + 1, 'h400, t * 'h111, w0, w1, wen, "R6 sweep");
        end
        if (!ended) begin
            ended = 1;
            summary();
            $finish;
        end
    end

endmodule